// File: doc/BRIEF.md
# Seven-to-One Serial Display Link Receiver

This block rebuilds parallel pixel words from a serial display link. It runs on a bit clock at seven times the pixel rate and takes, once per bit slot, one sample of every data lane plus one sample of the forwarded link-clock lane. The clock lane carries a fixed high/low pattern in every pixel period. The block finds the word boundary from that pattern and checks that the pattern repeats before it declares lock. It then packs the seven slots of each lane into one word and maps that word onto red, green and blue values, horizontal and vertical sync, data enable and a spare control bit.

All outputs of one word change together, on the bit-clock edge that samples the first slot of the next period. A pixel strobe is high for the first part of each period and falls while the data is stable, so a downstream stage can take the word on its falling edge. An active-low power-down input clears the outputs and the lock. After power-down is released, the outputs stay low until lock is found again. If the link clock stops toggling, the outputs keep their last word.

A parameter selects either four data lanes (28 bits per pixel) or three data lanes (21 bits per pixel, 6 bits per color). The analog receivers and the bit-clock generation sit outside this block.

Top module: `lvds_pixel_deser`

## Requirements
- R1: After reset all color, sync, data-enable and control outputs, `pixStrobe` and `locked` are 0.
- R2: The clock lane holds 1,1,1,1,0,0,0 in slots 0 to 6 of a pixel period. A period starts on a 0-to-1 change of the clock lane, and that change is judged against the line level seen in the previous slot, taken as 0 just after reset or power-down. A period is good when the next 0-to-1 change comes exactly 7 slots later and the 7 clock samples match the pattern. `locked` rises on the LOCK_PERIODS-th consecutive good period (default 3). Any 0-to-1 change that does not close a good period clears `locked` and the run count.
- R3: On every good period that leaves the block locked, the 7 samples of every lane are published together on the edge that samples slot 0 of the next period. Slot 0 is the sample taken with the 0-to-1 change. The outputs do not change on any other edge.
- R4: Four-lane map. A bit's index is lane*7+slot. red[5:0]=0..5, green[5:0]=6..11, blue[5:0]=12..17, hsync=18, vsync=19, de=20, red[7:6]=22:21, green[7:6]=24:23, blue[7:6]=26:25, ctl=27.
- R5: Three-lane mode (NUM_LANES=3) uses indices 0..20 exactly as in R4. Bits 7:6 of each color and `ctl` are 0.
- R6: While locked, `pixStrobe` is 1 in the 3 bit-clock cycles that start with a word update and 0 in the other 4 cycles of the period. Its falling edge therefore lands while the word is stable. It is 0 while not locked.
- R7: When `pwrDnN` is sampled low, all data outputs, `pixStrobe` and `locked` are 0 from the next edge on.
- R8: After `pwrDnN` returns high, the data outputs stay 0 until LOCK_PERIODS good periods have been seen again.
- R9: When the clock lane stops toggling, the outputs and `locked` keep their values and `pixStrobe` falls.
- R10: When lock is lost, the data outputs keep the last published word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven cycles per pixel period |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrDnN | input | 1 | Active-low power-down |
| clkLane | input | 1 | Sample of the forwarded link-clock lane for this slot |
| serIn | input | NUM_LANES (4) | Sample of each data lane for this slot |
| red | output | 8 | Red value |
| green | output | 8 | Green value |
| blue | output | 8 | Blue value |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| ctl | output | 1 | Spare control bit (0 in three-lane mode) |
| pixStrobe | output | 1 | Pixel strobe; the falling edge qualifies the data |
| locked | output | 1 | Word alignment found |

## Verification
On every cycle, the assertions check three things. Power-down clears the word, the lock and the strobe on the following edge. The published word stays frozen whenever no capture or clear is issued. Every capture starts a strobe pulse, and lock only rises after a good period. The bench scenarios show what a cycle-local property cannot: the exact lock count after idle, after a corrupted clock pattern and after power-down, and the bit map in both lane modes. They also show that the word is held through a stopped clock and through loss of lock, and the three-of-seven strobe duty.

// File: rtl/lvds_deser_pkg.sv
package lvds_deser_pkg;
  localparam int SLOTS     = 7;
  localparam int MAX_LANES = 4;
  localparam int MAX_BITS  = SLOTS * MAX_LANES;
  localparam int COLOR_W   = 8;
  localparam int BASE_W    = 6;

  // Clock-lane level per slot, bit k = slot k
  localparam logic [SLOTS-1:0] CLK_PATTERN = 7'b0001111;

  typedef struct packed {
    logic capture;
    logic clear;
  } ctlStrobes_t;

  typedef struct packed {
    logic [COLOR_W-1:0] red;
    logic [COLOR_W-1:0] green;
    logic [COLOR_W-1:0] blue;
    logic               hsync;
    logic               vsync;
    logic               de;
    logic               ctl;
  } pixel_t;

  // Fixed bit map, index = lane*SLOTS + slot
  function automatic pixel_t mapWord(input logic [MAX_BITS-1:0] b, input logic wide);
    pixel_t p;
    p = '0;
    p.red[BASE_W-1:0]   = b[BASE_W-1:0];
    p.green[BASE_W-1:0] = b[2*BASE_W-1:BASE_W];
    p.blue[BASE_W-1:0]  = b[3*BASE_W-1:2*BASE_W];
    p.hsync = b[3*BASE_W];
    p.vsync = b[3*BASE_W+1];
    p.de    = b[3*BASE_W+2];
    if (wide) begin
      p.red[COLOR_W-1:BASE_W]   = b[22:21];
      p.green[COLOR_W-1:BASE_W] = b[24:23];
      p.blue[COLOR_W-1:BASE_W]  = b[26:25];
      p.ctl = b[27];
    end
    return p;
  endfunction
endpackage

// File: rtl/lvds_deser_ctrl.sv
module lvds_deser_ctrl
  import lvds_deser_pkg::*;
#(
  parameter int LOCK_PERIODS = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwrDnN,
  input  logic        clkLane,
  output ctlStrobes_t strobes,
  output logic        locked,
  output logic        pixStrobe
);
  localparam int CNT_W = $clog2(SLOTS + 2);
  localparam int RUN_W = (LOCK_PERIODS < 2) ? 1 : $clog2(LOCK_PERIODS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SLOTS);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(SLOTS + 1);
  localparam logic [CNT_W-1:0] STB_LAST = CNT_W'((SLOTS - 1) / 2);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(LOCK_PERIODS);

  logic [SLOTS-1:0] clkHist;
  logic [CNT_W-1:0] slotCnt, slotCntNext;
  logic [RUN_W-1:0] goodRun;
  logic edgeSeen, goodPeriod, lockedNext;

  always_comb begin
    edgeSeen   = pwrDnN && !clkHist[SLOTS-1] && clkLane;
    goodPeriod = edgeSeen && (slotCnt == CNT_FULL) && (clkHist == CLK_PATTERN);
    if (edgeSeen)                slotCntNext = CNT_W'(1);
    else if (slotCnt == CNT_SAT) slotCntNext = slotCnt;
    else                         slotCntNext = slotCnt + CNT_W'(1);
    lockedNext = locked;
    if (goodPeriod)    lockedNext = (int'(goodRun) + 1) >= LOCK_PERIODS;
    else if (edgeSeen) lockedNext = 1'b0;
    strobes.capture = goodPeriod && lockedNext;
    strobes.clear   = !pwrDnN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkHist   <= '0;
      slotCnt   <= '0;
      goodRun   <= '0;
      locked    <= 1'b0;
      pixStrobe <= 1'b0;
    end else if (!pwrDnN) begin
      clkHist   <= '0;
      slotCnt   <= '0;
      goodRun   <= '0;
      locked    <= 1'b0;
      pixStrobe <= 1'b0;
    end else begin
      clkHist <= {clkLane, clkHist[SLOTS-1:1]};
      slotCnt <= slotCntNext;
      if (goodPeriod)    goodRun <= (goodRun == RUN_MAX) ? goodRun : goodRun + RUN_W'(1);
      else if (edgeSeen) goodRun <= '0;
      locked    <= lockedNext;
      pixStrobe <= lockedNext && (slotCntNext != '0) && (slotCntNext <= STB_LAST);
    end
  end

  // R7
  pd_unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDnN |=> (!locked && !pixStrobe));
  // R6
  strobe_after_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> pixStrobe);
  // R2
  lock_after_good_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(goodPeriod));
endmodule

// File: rtl/lvds_deser_datapath.sv
module lvds_deser_datapath
  import lvds_deser_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LANES-1:0] serIn,
  input  ctlStrobes_t          strobes,
  output pixel_t               pixOut
);
  localparam logic WIDE = (NUM_LANES == MAX_LANES);

  logic [MAX_BITS-1:0] flatWord;

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    logic [SLOTS-1:0] sr;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sr <= '0;
      else       sr <= {serIn[g], sr[SLOTS-1:1]};
    end
    assign flatWord[g*SLOTS +: SLOTS] = sr;
  end

  for (genvar g = NUM_LANES; g < MAX_LANES; g++) begin : gIdle
    assign flatWord[g*SLOTS +: SLOTS] = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                pixOut <= '0;
    else if (strobes.clear)   pixOut <= '0;
    else if (strobes.capture) pixOut <= mapWord(flatWord, WIDE);
  end

  // R7
  pd_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (pixOut == '0));
  // R3
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.capture && !strobes.clear) |=> $stable(pixOut));
endmodule

// File: rtl/lvds_pixel_deser.sv
module lvds_pixel_deser
  import lvds_deser_pkg::*;
#(
  parameter int NUM_LANES    = 4,
  parameter int LOCK_PERIODS = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pwrDnN,
  input  logic                 clkLane,
  input  logic [NUM_LANES-1:0] serIn,
  output logic [COLOR_W-1:0]   red,
  output logic [COLOR_W-1:0]   green,
  output logic [COLOR_W-1:0]   blue,
  output logic                 hsync,
  output logic                 vsync,
  output logic                 de,
  output logic                 ctl,
  output logic                 pixStrobe,
  output logic                 locked
);
  ctlStrobes_t strobes;
  pixel_t      pixWord;

  lvds_deser_ctrl #(.LOCK_PERIODS(LOCK_PERIODS)) uCtrl (
    .clk(clk), .rstN(rstN), .pwrDnN(pwrDnN), .clkLane(clkLane),
    .strobes(strobes), .locked(locked), .pixStrobe(pixStrobe)
  );

  lvds_deser_datapath #(.NUM_LANES(NUM_LANES)) uData (
    .clk(clk), .rstN(rstN), .serIn(serIn), .strobes(strobes), .pixOut(pixWord)
  );

  assign red   = pixWord.red;
  assign green = pixWord.green;
  assign blue  = pixWord.blue;
  assign hsync = pixWord.hsync;
  assign vsync = pixWord.vsync;
  assign de    = pixWord.de;
  assign ctl   = pixWord.ctl;
endmodule

// File: tb/sim_lvds_pixel_deser.sv
module sim_lvds_pixel_deser;
  localparam int LOCK = 3;

  logic clk = 1'b0;
  logic rstN, pwrDnN, clkLane;
  logic [3:0] serIn;
  logic [7:0] red0, green0, blue0, red1, green1, blue1;
  logic hs0, vs0, de0, ctl0, stb0, lk0, hs1, vs1, de1, ctl1, stb1, lk1;

  int nChecks = 0, nFails = 0, stbHigh = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lvds_pixel_deser #(.NUM_LANES(4), .LOCK_PERIODS(LOCK)) u0 (
    .clk(clk), .rstN(rstN), .pwrDnN(pwrDnN), .clkLane(clkLane), .serIn(serIn),
    .red(red0), .green(green0), .blue(blue0), .hsync(hs0), .vsync(vs0), .de(de0),
    .ctl(ctl0), .pixStrobe(stb0), .locked(lk0));

  lvds_pixel_deser #(.NUM_LANES(3), .LOCK_PERIODS(LOCK)) u1 (
    .clk(clk), .rstN(rstN), .pwrDnN(pwrDnN), .clkLane(clkLane), .serIn(serIn[2:0]),
    .red(red1), .green(green1), .blue(blue1), .hsync(hs1), .vsync(vs1), .de(de1),
    .ctl(ctl1), .pixStrobe(stb1), .locked(lk1));

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Word content per index
  function automatic logic [7:0] redOf(input int i);   return 8'hC3 ^ 8'(i * 29); endfunction
  function automatic logic [7:0] greenOf(input int i); return 8'h5A + 8'(i * 71); endfunction
  function automatic logic [7:0] blueOf(input int i);  return ~(8'h36 ^ 8'(i * 13)); endfunction
  function automatic logic [27:0] wordOf(input int i);
    logic [27:0] w;
    logic [7:0] r, g, b;
    r = redOf(i); g = greenOf(i); b = blueOf(i);
    w[5:0] = r[5:0]; w[11:6] = g[5:0]; w[17:12] = b[5:0];
    w[18] = i[0]; w[19] = i[1]; w[20] = 1'b1;
    w[22:21] = r[7:6]; w[24:23] = g[7:6]; w[26:25] = b[7:6];
    w[27] = ~i[0];
    return w;
  endfunction

  // Behavioural reference
  logic clkQ[$];
  logic [3:0] datQ[$];
  int sinceRise = 0, goodRun = 0;
  bit mLocked = 0, mStb = 0;
  logic [27:0] expWord = '0;

  always @(posedge clk) begin
    if (!rstN || !pwrDnN) begin
      clkQ.delete(); datQ.delete();
      sinceRise = 0; goodRun = 0; mLocked = 0; mStb = 0; expWord = '0;
    end else begin
      logic prevC;
      bit good;
      prevC = (clkQ.size() > 0) ? clkQ[$] : 1'b0;
      if (!prevC && clkLane) begin
        good = (sinceRise == 7);
        if (good)
          for (int k = 0; k < 7; k++)
            if (clkQ[clkQ.size() - 7 + k] != (k < 4)) good = 0;
        if (good) begin
          if (goodRun < LOCK) goodRun++;
          if (goodRun >= LOCK) begin
            mLocked = 1;
            for (int l = 0; l < 4; l++)
              for (int k = 0; k < 7; k++)
                expWord[l*7 + k] = datQ[datQ.size() - 7 + k][l];
          end
        end else begin
          goodRun = 0; mLocked = 0;
        end
        sinceRise = 1;
      end else if (sinceRise < 8) sinceRise++;
      clkQ.push_back(clkLane); datQ.push_back(serIn);
      if (clkQ.size() > 8) begin void'(clkQ.pop_front()); void'(datQ.pop_front()); end
      mStb = mLocked && sinceRise >= 1 && sinceRise <= 3;
    end
  end

  // Per-cycle comparison
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R4", "red",   32'(red0),   32'({expWord[22:21], expWord[5:0]}));
      check("R4", "green", 32'(green0), 32'({expWord[24:23], expWord[11:6]}));
      check("R4", "blue",  32'(blue0),  32'({expWord[26:25], expWord[17:12]}));
      check("R4", "sync/de/ctl", 32'({hs0, vs0, de0, ctl0}),
            32'({expWord[18], expWord[19], expWord[20], expWord[27]}));
      check("R5", "red",   32'(red1),   32'({2'b00, expWord[5:0]}));
      check("R5", "green", 32'(green1), 32'({2'b00, expWord[11:6]}));
      check("R5", "blue",  32'(blue1),  32'({2'b00, expWord[17:12]}));
      check("R5", "sync/de/ctl", 32'({hs1, vs1, de1, ctl1}),
            32'({expWord[18], expWord[19], expWord[20], 1'b0}));
      check("R2", "locked", 32'({lk0, lk1}), 32'({mLocked, mLocked}));
      check("R6", "pixStrobe", 32'({stb0, stb1}), 32'({mStb, mStb}));
    end
  end

  task automatic sendWord(input int idx, input bit badClk);
    logic [27:0] w;
    w = wordOf(idx);
    for (int s = 0; s < 7; s++) begin
      @(negedge clk);
      if (stb0) stbHigh++;
      clkLane = badClk ? (s < 3) : (s < 4);
      for (int l = 0; l < 4; l++) serIn[l] = w[l*7 + s];
    end
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      clkLane = 1'b0; serIn = '0;
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    rstN = 1'b0; pwrDnN = 1'b1; clkLane = 1'b0; serIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "reset outputs", 32'({red0, green0, blue0, hs0, vs0, de0, ctl0}), 32'(0));
    check("R1", "reset lock/strobe", 32'({lk0, stb0, lk1, stb1}), 32'(0));
    idle(10);

    for (int i = 1; i <= 4; i++) sendWord(i, 0);
    check("R2", "locked after third good period", 32'(lk0), 32'(1));
    check("R3", "first published word", 32'(red0), 32'(redOf(3)));
    check("R5", "narrow ctl low", 32'(ctl1), 32'(0));
    check("R5", "narrow red", 32'(red1), 32'({2'b00, redOf(3)[5:0]}));
    sendWord(5, 0);
    check("R3", "word green", 32'(green0), 32'(greenOf(4)));
    check("R3", "word blue", 32'(blue0), 32'(blueOf(4)));

    idle(20);
    check("R9", "stopped clock holds red", 32'(red0), 32'(redOf(4)));
    check("R9", "stopped clock keeps lock", 32'(lk0), 32'(1));
    check("R9", "stopped clock strobe", 32'(stb0), 32'(0));

    sendWord(6, 0);
    check("R10", "lock dropped", 32'(lk0), 32'(0));
    check("R10", "word kept after lock loss", 32'(red0), 32'(redOf(4)));

    for (int i = 7; i <= 9; i++) sendWord(i, 0);
    check("R2", "relock", 32'(lk0), 32'(1));
    check("R3", "word after relock", 32'(red0), 32'(redOf(8)));

    sendWord(10, 1);
    check("R3", "word before bad pattern", 32'(red0), 32'(redOf(9)));
    sendWord(11, 0);
    check("R2", "bad clock pattern drops lock", 32'(lk0), 32'(0));
    check("R10", "word kept after bad pattern", 32'(red0), 32'(redOf(9)));

    for (int i = 12; i <= 15; i++) sendWord(i, 0);
    check("R2", "lock after bad pattern", 32'(lk0), 32'(1));
    stbHigh = 0;
    sendWord(16, 0);
    check("R6", "strobe high cycles per period", 32'(stbHigh), 32'(3));

    pwrDnN = 1'b0;
    sendWord(17, 0);
    check("R7", "power-down word", 32'({red0, green0, blue0, hs0, vs0, de0, ctl0}), 32'(0));
    check("R7", "power-down lock/strobe", 32'({lk0, stb0, lk1, stb1}), 32'(0));
    pwrDnN = 1'b1;
    sendWord(18, 0);
    sendWord(19, 0);
    check("R8", "low until relock", 32'({red0, green0, blue0, de0}), 32'(0));
    check("R8", "unlocked after release", 32'(lk0), 32'(0));
    sendWord(20, 0);
    sendWord(21, 0);
    check("R8", "word after relock", 32'(red0), 32'(redOf(20)));
    check("R8", "locked after release", 32'(lk0), 32'(1));
    idle(5);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nFails++;
      $display("FAIL R3 watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule